// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block serializes words onto an SPI bus as the bus master. A run is launched with a one-cycle start pulse. It then moves a programmed number of words. Each word holds between 1 and 32 bits, and the bits go out most-significant first or least-significant first. The SCLK idle level and the sampling edge are both selectable, which covers the four usual clock modes.

Transmit words come from a first-word-fall-through FIFO, shown to the block as head data plus an empty flag. The block acknowledges each word with a pop strobe. Received words leave through a push strobe into a receive FIFO that reports when it is full. Transmit and receive can each be turned off, so a run can be transmit-only, receive-only or full duplex.

There are four chip-select lines, each with its own polarity. A software override can force the selected line, and a keep bit holds the select asserted across the words of a run. On completion the block raises a ready flag and, if enabled, an interrupt. It also reports any transmit underflow or receive overflow seen during the run.

Top module: `spi_eng`

## Requirements
- R1: A run moves `word_cnt_m1`+1 words, each of `frame_len_m1`+1 bits (1 to 32). The next start is taken only after the last bit of the last word.
- R2: While no run is active, `sclk` equals `clk_idle_high`. During a run each bit lasts 2·(`half_period_m1`+1) core cycles.
- R2 (sampling edge): With `late_sample`=0, data is driven before the first SCLK edge of a bit and sampled on that edge. With `late_sample`=1, data changes on the first edge and is sampled on the second.
- R3: `cs_sel` picks one of the four lines. A line is asserted when its level equals its `cs_active_high` bit (1 means high-active). At most one line is ever asserted, and during shifting it is exactly the selected one.
- R4: With `cs_override`=1, the selected line is asserted exactly when `cs_override_val`=1, whether or not a run is active. With `cs_override`=0 and no run active, every line is deasserted.
- R5: With `cs_keep`=1, the select asserts once per run and stays asserted between words. With `cs_keep`=0, it deasserts between words and asserts once per word.
- R6: With `lsb_first`=0, word bit n-1 is sent first. With `lsb_first`=1, bit 0 is sent first. Received words are right-aligned in `rx_data` and use the same order.
- R7: With `tx_enable`=0, no word is popped and `mosi` stays 0. With `rx_enable`=0, no word is pushed.
- R8: `busy` is high from the cycle after an accepted start until the run ends. `ready` is set at the end of the run and cleared by `ready_clr`. A start pulse during a run is ignored.
- R9: `irq` is set at run end when (`tx_enable` and `tx_done_ie`) or (`rx_enable` and `rx_done_ie`). It is cleared together with `ready`.
- R10: If the TX FIFO is empty when a word is due, `tx_underflow` is set and that word goes out as all zeros. The flag is cleared by the next start.
- R11: If the RX FIFO is full when a word completes, `rx_overflow` is set and the word is dropped. The flag is cleared by the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a run |
| ready_clr | input | 1 | Clears ready and irq |
| frame_len_m1 | input | 5 | Bits per word minus one |
| word_cnt_m1 | input | CNT_W | Words per run minus one |
| half_period_m1 | input | DIV_W | SCLK half period in core cycles, minus one |
| clk_idle_high | input | 1 | SCLK idle level |
| late_sample | input | 1 | Sample on the second edge of each bit |
| lsb_first | input | 1 | Least-significant bit first |
| tx_enable | input | 1 | Take words from the TX FIFO |
| rx_enable | input | 1 | Push received words |
| tx_done_ie | input | 1 | Interrupt enable for transmit runs |
| rx_done_ie | input | 1 | Interrupt enable for receive runs |
| cs_sel | input | log2(NUM_CS) | Selected chip-select line |
| cs_active_high | input | NUM_CS | Per-line active level |
| cs_override | input | 1 | Software control of the selected line |
| cs_override_val | input | 1 | Forced assert value |
| cs_keep | input | 1 | Hold select between words |
| tx_data | input | 32 | TX FIFO head word |
| tx_empty | input | 1 | TX FIFO empty |
| tx_pop | output | 1 | Consume TX FIFO head |
| rx_data | output | 32 | Received word |
| rx_full | input | 1 | RX FIFO full |
| rx_push | output | 1 | Write rx_data into the RX FIFO |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | NUM_CS | Chip-select line levels |
| busy | output | 1 | Run in progress |
| ready | output | 1 | Run completed, sticky |
| irq | output | 1 | Completion interrupt |
| tx_underflow | output | 1 | TX FIFO ran dry during the run |
| rx_overflow | output | 1 | A word was dropped on a full RX FIFO |

## Verification
The properties assume that every configuration input stays constant while `busy` is high. They also assume that the FIFO status inputs tell the truth: the head word is valid whenever `tx_empty` is low. The stimulus changes the mode, select and polarity inputs only between runs, after `busy` has fallen. It models both FIFOs with pointers that advance only on the block's own pop and push strobes. The serial slave model shifts its bit stream on the edge opposite the sampling edge for the configured mode. This keeps `miso` stable wherever the block samples it.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    localparam int unsigned DW = 32;
    localparam int unsigned LW = $clog2(DW);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_GAP
    } eng_state_e;

    // per-word shifting context
    typedef struct packed {
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
        logic [LW-1:0] idx;
        logic          ph;
    } word_ctx_t;

    // wire position of serial bit number idx within a word whose top bit is last
    function automatic logic [LW-1:0] bit_slot(input logic [LW-1:0] idx,
                                               input logic [LW-1:0] last,
                                               input logic lsb);
        return lsb ? idx : last - idx;
    endfunction

    // SCLK level: idle outside shifting, phase-dependent inside
    function automatic logic clk_level(input logic cpol, input logic cpha,
                                       input logic ph, input logic shifting);
        return shifting ? (cpol ^ cpha ^ ph) : cpol;
    endfunction

endpackage

// File: rtl/spi_eng_timer.sv
module spi_eng_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hold,
    input  logic [DIV_W-1:0] limit,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = !hold && (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || hold || tick)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_eng_csdec.sv
module spi_eng_csdec #(
    parameter int NUM_CS = 4,
    localparam int SW = $clog2(NUM_CS)
) (
    input  logic [SW-1:0]     sel,
    input  logic [NUM_CS-1:0] pol,
    input  logic              act,
    output logic [NUM_CS-1:0] lines
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_line
        localparam logic [SW-1:0] IDX = SW'(i);
        assign lines[i] = (act && sel == IDX) ? pol[i] : ~pol[i];
    end
endmodule

// File: rtl/spi_eng.sv
module spi_eng
    import spi_eng_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int CNT_W  = 16,
    parameter int DIV_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic                      ready_clr,
    input  logic [LW-1:0]             frame_len_m1,
    input  logic [CNT_W-1:0]          word_cnt_m1,
    input  logic [DIV_W-1:0]          half_period_m1,
    input  logic                      clk_idle_high,
    input  logic                      late_sample,
    input  logic                      lsb_first,
    input  logic                      tx_enable,
    input  logic                      rx_enable,
    input  logic                      tx_done_ie,
    input  logic                      rx_done_ie,
    input  logic [$clog2(NUM_CS)-1:0] cs_sel,
    input  logic [NUM_CS-1:0]         cs_active_high,
    input  logic                      cs_override,
    input  logic                      cs_override_val,
    input  logic                      cs_keep,
    input  logic [DW-1:0]             tx_data,
    input  logic                      tx_empty,
    output logic                      tx_pop,
    output logic [DW-1:0]             rx_data,
    input  logic                      rx_full,
    output logic                      rx_push,
    output logic                      sclk,
    output logic                      mosi,
    input  logic                      miso,
    output logic [NUM_CS-1:0]         cs_o,
    output logic                      busy,
    output logic                      ready,
    output logic                      irq,
    output logic                      tx_underflow,
    output logic                      rx_overflow
);
    eng_state_e       st;
    word_ctx_t        ctx;
    logic [CNT_W-1:0] widx;
    logic             tick, shifting, samp, bit_end, word_end, run_end, cs_act;
    logic [LW-1:0]    slot;

    spi_eng_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .hold  (!(st == ST_SHIFT || st == ST_GAP)),
        .limit (half_period_m1),
        .tick  (tick)
    );

    assign shifting = (st == ST_SHIFT);
    assign samp     = shifting && tick && !ctx.ph;
    assign bit_end  = shifting && tick && ctx.ph;
    assign word_end = bit_end && (ctx.idx == frame_len_m1);
    assign run_end  = word_end && (widx == word_cnt_m1);
    assign slot     = bit_slot(ctx.idx, frame_len_m1, lsb_first);

    assign busy    = (st != ST_IDLE);
    assign sclk    = clk_level(clk_idle_high, late_sample, ctx.ph, shifting);
    assign mosi    = shifting && tx_enable && ctx.tx[slot];
    assign tx_pop  = (st == ST_LOAD) && tx_enable && !tx_empty;
    assign rx_push = word_end && rx_enable && !rx_full;
    assign rx_data = ctx.rx;

    assign cs_act = cs_override ? cs_override_val
                                : (shifting || (cs_keep && busy));

    spi_eng_csdec #(.NUM_CS(NUM_CS)) u_cs (
        .sel   (cs_sel),
        .pol   (cs_active_high),
        .act   (cs_act),
        .lines (cs_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= ST_IDLE;
            ctx          <= '0;
            widx         <= '0;
            tx_underflow <= 1'b0;
            rx_overflow  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st           <= ST_LOAD;
                        widx         <= '0;
                        tx_underflow <= 1'b0;
                        rx_overflow  <= 1'b0;
                    end
                end
                ST_LOAD: begin
                    ctx.tx  <= tx_pop ? tx_data : '0;
                    ctx.rx  <= '0;
                    ctx.idx <= '0;
                    ctx.ph  <= 1'b0;
                    if (tx_enable && tx_empty)
                        tx_underflow <= 1'b1;
                    st <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (samp) begin
                        ctx.rx[slot] <= miso;
                        ctx.ph       <= 1'b1;
                    end
                    if (bit_end) begin
                        ctx.ph <= 1'b0;
                        if (word_end) begin
                            if (rx_enable && rx_full)
                                rx_overflow <= 1'b1;
                            if (run_end) begin
                                st <= ST_IDLE;
                            end else begin
                                widx <= widx + 1'b1;
                                st   <= cs_keep ? ST_LOAD : ST_GAP;
                            end
                        end else begin
                            ctx.idx <= ctx.idx + 1'b1;
                        end
                    end
                end
                ST_GAP: begin
                    if (tick)
                        st <= ST_LOAD;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b0;
            irq   <= 1'b0;
        end else if (run_end) begin
            ready <= 1'b1;
            irq   <= (tx_enable && tx_done_ie) || (rx_enable && rx_done_ie);
        end else if (ready_clr) begin
            ready <= 1'b0;
            irq   <= 1'b0;
        end
    end
endmodule

// File: rtl/spi_eng_chk.sv
module spi_eng_chk #(
    parameter int NUM_CS = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              ready,
    input logic              irq,
    input logic              sclk,
    input logic              clk_idle_high,
    input logic              mosi,
    input logic [NUM_CS-1:0] cs_o,
    input logic [NUM_CS-1:0] cs_active_high,
    input logic              cs_override,
    input logic              tx_pop,
    input logic              tx_empty,
    input logic              tx_enable,
    input logic              rx_push,
    input logic              rx_full,
    input logic              rx_enable
);
    // R2
    idle_clk_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == clk_idle_high));

    // R3
    single_cs_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~(cs_o ^ cs_active_high)));

    // R4
    cs_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !cs_override) |-> (cs_o == ~cs_active_high));

    // R7
    pop_ok_chk: assert property (@(posedge clk) disable iff (rst)
        tx_pop |-> (tx_enable && !tx_empty));

    // R7
    quiet_mosi_chk: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |-> !mosi);

    // R11
    push_ok_chk: assert property (@(posedge clk) disable iff (rst)
        rx_push |-> (rx_enable && !rx_full));

    // R8
    start_take_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R8
    done_ready_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ready);

    // R9
    irq_ready_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> ready);
endmodule

bind spi_eng spi_eng_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .start          (start),
    .busy           (busy),
    .ready          (ready),
    .irq            (irq),
    .sclk           (sclk),
    .clk_idle_high  (clk_idle_high),
    .mosi           (mosi),
    .cs_o           (cs_o),
    .cs_active_high (cs_active_high),
    .cs_override    (cs_override),
    .tx_pop         (tx_pop),
    .tx_empty       (tx_empty),
    .tx_enable      (tx_enable),
    .rx_push        (rx_push),
    .rx_full        (rx_full),
    .rx_enable      (rx_enable)
);

// File: tb/spi_eng_tb.sv
module spi_eng_tb;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, rclr = 1'b0;
    logic [4:0]  len_m1 = 5'd7;
    logic [15:0] wcm1 = '0;
    logic [7:0]  hp = 8'd1;
    logic        cpol = 1'b0, cpha = 1'b0, lsb = 1'b0;
    logic        txe = 1'b1, rxe = 1'b1, txie = 1'b1, rxie = 1'b1;
    logic [1:0]  sel = '0;
    logic [3:0]  pol = '0;
    logic        ovr = 1'b0, ovr_v = 1'b0, keep = 1'b0;
    logic [31:0] tx_data, rx_data;
    logic        tx_empty, tx_pop, rx_full, rx_push;
    logic        sclk, mosi, miso = 1'b0;
    logic [3:0]  cs_o;
    logic        busy, ready, irq, tx_unf, rx_ovf;

    always #(CLK_P/2) clk = ~clk;

    spi_eng u_dut (
        .clk(clk), .rst(rst), .start(start), .ready_clr(rclr),
        .frame_len_m1(len_m1), .word_cnt_m1(wcm1), .half_period_m1(hp),
        .clk_idle_high(cpol), .late_sample(cpha), .lsb_first(lsb),
        .tx_enable(txe), .rx_enable(rxe), .tx_done_ie(txie), .rx_done_ie(rxie),
        .cs_sel(sel), .cs_active_high(pol), .cs_override(ovr),
        .cs_override_val(ovr_v), .cs_keep(keep),
        .tx_data(tx_data), .tx_empty(tx_empty), .tx_pop(tx_pop),
        .rx_data(rx_data), .rx_full(rx_full), .rx_push(rx_push),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_o(cs_o),
        .busy(busy), .ready(ready), .irq(irq),
        .tx_underflow(tx_unf), .rx_overflow(rx_ovf)
    );

    // FIFO models
    logic [31:0] tx_mem [64];
    int tx_wr = 0, tx_rd = 0, rx_cnt = 0, rx_base = 0, rx_cap = 1000;
    assign tx_empty = (tx_rd == tx_wr);
    assign tx_data  = tx_mem[tx_rd % 64];
    assign rx_full  = (rx_cnt - rx_base) >= rx_cap;
    always @(posedge clk) begin
        if (tx_pop)  tx_rd  <= tx_rd + 1;
        if (rx_push) rx_cnt <= rx_cnt + 1;
    end

    // scoreboard
    logic [31:0] exp_mosi[$];
    logic [31:0] exp_rx[$];
    logic        mbits[$];
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input int n);
        return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
    endfunction

    function automatic logic [31:0] pat(input int s, input int i);
        return (32'h9E37_79B9 * (i + 1)) ^ (32'h0F0F_1357 << (s % 8)) ^ s;
    endfunction

    // RX monitor
    always @(negedge clk) begin
        if (rx_push) begin
            if (exp_rx.size() == 0)
                chk(0, "R1 unexpected rx word", rx_data, 32'h0);
            else begin
                logic [31:0] e;
                e = exp_rx.pop_front();
                chk(rx_data == e, "R6 rx word", rx_data, e);
            end
        end
    end

    // serial slave model and MOSI monitor
    logic busy_q = 1'b0, sclk_q = 1'b0;
    int   bcnt = 0, lead_cnt = 0, cs_bad = 0, asserts = 0;
    time  t_first = 0, period = 0;
    logic [31:0] mw = '0;
    always @(sclk or busy) begin
        int n;
        n = int'(len_m1) + 1;
        if (busy && !busy_q) begin
            lead_cnt = 0;
            bcnt = 0;
            mw = '0;
            if (!cpha && mbits.size() > 0) miso = mbits.pop_front();
        end else if (busy && sclk != sclk_q) begin
            logic lead;
            lead = (sclk != cpol);
            if (lead) begin
                lead_cnt++;
                if (lead_cnt == 1) t_first = $time;
                if (lead_cnt == 2) period = $time - t_first;
            end
            if (lead ^ cpha) begin
                if (~(cs_o ^ pol) != (4'b1 << sel)) cs_bad++;
                mw[lsb ? bcnt : n - 1 - bcnt] = mosi;
                bcnt++;
                if (bcnt == n) begin
                    if (exp_mosi.size() == 0)
                        chk(0, "R1 unexpected mosi word", mw, 32'h0);
                    else begin
                        logic [31:0] e;
                        e = exp_mosi.pop_front();
                        chk(mw == e, "R6 mosi word", mw, e);
                    end
                    bcnt = 0;
                    mw = '0;
                end
            end else if (mbits.size() > 0) begin
                miso = mbits.pop_front();
            end
        end
        busy_q = busy;
        sclk_q = sclk;
    end

    logic act_q = 1'b0;
    always @(cs_o or sel or pol) begin
        logic [3:0] a;
        a = ~(cs_o ^ pol);
        if (a[sel] && !act_q) asserts++;
        act_q = a[sel];
    end

    task automatic do_run(input int seed, input int nw, input int ntx, input int cap);
        int n;
        logic [31:0] m;
        int rx_before;
        n = int'(len_m1) + 1;
        m = mask_of(n);
        wcm1 = 16'(nw - 1);
        rx_cap = cap;
        rx_base = rx_cnt;
        rx_before = rx_cnt;
        for (int i = 0; i < nw; i++) begin
            logic [31:0] tw, rw;
            tw = pat(seed, i);
            rw = pat(seed + 77, i);
            if (txe && i < ntx) begin
                tx_mem[tx_wr % 64] = tw;
                tx_wr++;
            end
            exp_mosi.push_back((txe && i < ntx) ? (tw & m) : 32'h0);
            for (int b = 0; b < n; b++)
                mbits.push_back(rw[lsb ? b : n - 1 - b]);
            if (rxe && i < cap) exp_rx.push_back(rw & m);
        end
        asserts = 0;
        cs_bad = 0;
        period = 0;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(exp_mosi.size() == 0, "R1 all mosi words seen", 32'(exp_mosi.size()), 0);
        chk(exp_rx.size() == 0, "R1 all rx words seen", 32'(exp_rx.size()), 0);
        chk(rx_cnt - rx_before == ((rxe) ? ((nw < cap) ? nw : cap) : 0),
            "R7 rx push count", 32'(rx_cnt - rx_before), 32'((rxe) ? ((nw < cap) ? nw : cap) : 0));
        chk(tx_rd == tx_wr, "R7 tx pops", 32'(tx_rd), 32'(tx_wr));
        chk(cs_bad == 0, "R3 select during shift", 32'(cs_bad), 0);
        chk(sclk == cpol, "R2 idle sclk", 32'(sclk), 32'(cpol));
        if (n >= 2)
            chk(period == time'(2 * (int'(hp) + 1) * CLK_P), "R2 bit period",
                32'(period), 32'(2 * (int'(hp) + 1) * CLK_P));
        chk(ready == 1'b1, "R8 ready at end", 32'(ready), 1);
        chk(irq == ((txe & txie) | (rxe & rxie)), "R9 irq", 32'(irq), 32'((txe & txie) | (rxe & rxie)));
    endtask

    task automatic clear_ready();
        @(negedge clk) rclr = 1'b1;
        @(negedge clk) rclr = 1'b0;
        chk(ready == 1'b0, "R8 ready cleared", 32'(ready), 0);
        chk(irq == 1'b0, "R9 irq cleared", 32'(irq), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(busy == 1'b0 && ready == 1'b0 && irq == 1'b0, "R8 reset status",
            {29'b0, busy, ready, irq}, 0);
        chk(cs_o == 4'hF, "R4 reset cs", 32'(cs_o), 32'hF);
        rst = 1'b0;
        @(negedge clk);

        // mode 0, 8-bit MSB first, select per word
        do_run(1, 4, 4, 1000);
        chk(asserts == 4, "R5 select per word", 32'(asserts), 4);
        clear_ready();

        // mode 3, 32-bit LSB first, held select, high-active line 2
        cpol = 1; cpha = 1; lsb = 1; len_m1 = 5'd31; keep = 1; sel = 2'd2; pol = 4'b0100; hp = 8'd2;
        @(negedge clk);
        do_run(2, 3, 3, 1000);
        chk(asserts == 1, "R5 select held", 32'(asserts), 1);
        clear_ready();

        // mode 1, 1-bit frames, receive only, tx irq enable only
        cpol = 0; cpha = 1; lsb = 0; len_m1 = 5'd0; keep = 0; sel = 2'd3; pol = 4'b0000;
        txe = 0; rxie = 0; hp = 8'd0;
        @(negedge clk);
        do_run(3, 5, 0, 1000);
        chk(asserts == 5, "R1 five one-bit words", 32'(asserts), 5);
        clear_ready();

        // mode 2, 13-bit transmit only
        cpol = 1; cpha = 0; len_m1 = 5'd12; txe = 1; rxe = 0; txie = 1; rxie = 1; sel = 2'd1; hp = 8'd3;
        @(negedge clk);
        do_run(4, 3, 3, 1000);
        clear_ready();

        // transmit underflow
        cpol = 0; len_m1 = 5'd15; rxe = 1; hp = 8'd1;
        @(negedge clk);
        do_run(5, 4, 2, 1000);
        chk(tx_unf == 1'b1, "R10 underflow flagged", 32'(tx_unf), 1);
        clear_ready();
        do_run(6, 2, 2, 1000);
        chk(tx_unf == 1'b0, "R10 underflow cleared by start", 32'(tx_unf), 0);
        clear_ready();

        // receive overflow
        do_run(7, 4, 4, 2);
        chk(rx_ovf == 1'b1, "R11 overflow flagged", 32'(rx_ovf), 1);
        clear_ready();

        // start during run ignored
        len_m1 = 5'd7;
        @(negedge clk);
        fork
            do_run(8, 2, 2, 1000);
            begin
                repeat (10) @(negedge clk);
                start = 1'b1;
                @(negedge clk) start = 1'b0;
            end
        join
        repeat (5) @(negedge clk);
        chk(busy == 1'b0, "R8 start while busy ignored", 32'(busy), 0);
        clear_ready();

        // override
        ovr = 1; ovr_v = 1; sel = 2'd1; pol = 4'b0000;
        @(negedge clk);
        chk(cs_o == 4'b1101, "R4 forced on", 32'(cs_o), 32'hD);
        ovr_v = 0;
        @(negedge clk);
        chk(cs_o == 4'b1111, "R4 forced off", 32'(cs_o), 32'hF);
        ovr_v = 1;
        @(negedge clk);
        do_run(9, 2, 2, 1000);
        chk(asserts == 0 && cs_o == 4'b1101, "R4 forced through run", {28'(asserts), cs_o}, 32'hD);
        clear_ready();

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish actual=0 expected=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule